// File: doc/BRIEF.md
# FIFO Level Readout Register Window

This block is a slice of a UART register file. One register address is shared by three functions: a general-purpose 8-bit scratchpad, a write-only extended mode register, and a read-only FIFO level view. An external swap control bit picks which function the address serves. When the swap bit is clear, the address behaves as a plain read/write scratchpad. When the swap bit is set, writes go to the mode register and reads return a FIFO occupancy count.

The mode register has two fields. Its low two bits choose the level source: the receive count, the transmit count, or an alternating mode. In alternating mode, successive level reads return the receive count and the transmit count in turn. A second field holds an RTS hysteresis code. The block only stores this code and drives it out; it does not act on it.

A separate FIFO data count register also lives in this block. The surrounding register file decodes it through the alternate register set and gives it its own select. A direction bit chooses whether this register returns the transmit count or the receive count. The FIFOs, framing, baud generation and RTS pin control are all outside this block.

Top module: `fifo_level_window`

## Requirements
- R1: After reset, the scratchpad reads 0x00, `hyst_sel` is 0, and the level source is the receive count.
- R2: With `swap_en`=0, a write strobe with `win_sel` stores `wdata` in the scratchpad. A read strobe with `win_sel` returns the stored byte in the same cycle.
- R3: With `swap_en`=1, a write to the shared address loads the mode register and leaves the scratchpad unchanged. Setting `swap_en` back to 0 reads the old scratchpad value.
- R4: With `swap_en`=1, a read of the shared address returns the level. Mode bits [1:0] select the source: 00 gives the receive count, 01 the transmit count, and 10 the receive count.
- R5: In mode 11, the first level read after a mode write returns the receive count. Later level reads alternate: transmit, receive, transmit, and so on.
- R6: Every write to the mode register restarts the alternation, so the next level read returns the receive count.
- R7: The alternation advances only on a read strobe to the shared address with `swap_en`=1. Idle cycles, scratchpad reads and count register reads leave it unchanged.
- R8: `hyst_sel` equals bits [5:4] of the last mode write. Bits [3:2] and [7:6] of that write have no effect on the level source or on `hyst_sel`.
- R9: A read strobe with `cnt_sel` returns `tx_count` when `cnt_dir_tx`=1 and `rx_count` when it is 0. This holds whatever the value of `swap_en` or the mode.
- R10: `rdata` is 0x00 in any cycle without a read strobe to either select.
- R11: The counts are taken combinationally in the read cycle, over the full range 0 to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Single-cycle register write strobe |
| rd_stb | input | 1 | Single-cycle register read strobe |
| win_sel | input | 1 | Decode enable for the shared scratchpad/mode/level address |
| cnt_sel | input | 1 | Decode enable for the FIFO data count register (alternate set) |
| swap_en | input | 1 | Swap control: 1 routes the shared address to mode/level |
| cnt_dir_tx | input | 1 | Count register direction: 1 transmit, 0 receive |
| wdata | input | 8 | Write data bus |
| rx_count | input | 8 | Receive FIFO occupancy, 0..128 |
| tx_count | input | 8 | Transmit FIFO occupancy, 0..128 |
| rdata | output | 8 | Read data, 0 when no read is selected |
| hyst_sel | output | 2 | Stored RTS hysteresis code |

## Verification
The assertions rely on three properties of the inputs. First, the two decode enables are never high together. Second, the occupancy counts never exceed 128. Third, a read strobe and a write strobe never fall in the same cycle. The stimulus meets all three. It drives one operation per step, with only one select set. It also keeps every count value between 0 and 128, and the tests include both end values.

// File: rtl/fifo_win_pkg.sv
package fifo_win_pkg;
   typedef enum logic [1:0] {
      SRC_RX     = 2'b00,
      SRC_TX     = 2'b01,
      SRC_RX_ALT = 2'b10,
      SRC_ALTERN = 2'b11
   } lvl_src_e;

   localparam int SRC_W = 2;
endpackage

// File: rtl/fwin_mode_store.sv
module fwin_mode_store
   import fifo_win_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int HYST_LSB = 4,
   parameter int HYST_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              swap_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] scratch,
   output lvl_src_e          src,
   output logic [HYST_W-1:0] hyst,
   output logic              mode_wr
);
   logic scratch_wr;

   assign scratch_wr = wr_en & ~swap_en;
   assign mode_wr    = wr_en &  swap_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch <= '0;
      end else if (scratch_wr) begin
         scratch <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= SRC_RX;
         hyst <= '0;
      end else if (mode_wr) begin
         src  <= lvl_src_e'(wdata[SRC_W-1:0]);
         hyst <= wdata[HYST_LSB +: HYST_W];
      end
   end

   assert_scratch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && swap_en) |=> (scratch == $past(scratch)));

   assert_hyst_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && swap_en) |=> (hyst == $past(wdata[HYST_LSB +: HYST_W])));

   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && swap_en) |=> ($stable(src) && $stable(hyst)));
endmodule

// File: rtl/fwin_count_ext.sv
module fwin_count_ext #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              dir_tx,
   output logic [DATA_W-1:0] rx_word,
   output logic [DATA_W-1:0] tx_word,
   output logic [DATA_W-1:0] dir_word
);
   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (PAD_W == 0) begin : g_flat
         assign rx_word = rx_count;
         assign tx_word = tx_count;
      end else begin : g_pad
         assign rx_word = {{PAD_W{1'b0}}, rx_count};
         assign tx_word = {{PAD_W{1'b0}}, tx_count};
      end
   endgenerate

   assign dir_word = dir_tx ? tx_word : rx_word;
endmodule

// File: rtl/fwin_level_sel.sv
module fwin_level_sel
   import fifo_win_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              lvl_rd,
   input  lvl_src_e          src,
   input  logic [DATA_W-1:0] rx_word,
   input  logic [DATA_W-1:0] tx_word,
   output logic [DATA_W-1:0] level
);
   logic on_tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_tx <= 1'b0;
      end else if (mode_wr) begin
         on_tx <= 1'b0;
      end else if (lvl_rd && (src == SRC_ALTERN)) begin
         on_tx <= ~on_tx;
      end
   end

   always_comb begin
      unique case (src)
         SRC_TX:     level = tx_word;
         SRC_ALTERN: level = on_tx ? tx_word : rx_word;
         default:    level = rx_word;
      endcase
   end

   assert_restart_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !on_tx);

   assert_alt_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_rd && !mode_wr && src == SRC_ALTERN) |=> (on_tx != $past(on_tx)));

   assert_alt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lvl_rd || mode_wr) |=> $stable(on_tx));
endmodule

// File: rtl/fifo_level_window.sv
module fifo_level_window #(
   parameter int DATA_W   = 8,
   parameter int CNT_MAX  = 128,
   parameter int CNT_W    = $clog2(CNT_MAX + 1),
   parameter int HYST_LSB = 4,
   parameter int HYST_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic              win_sel,
   input  logic              cnt_sel,
   input  logic              swap_en,
   input  logic              cnt_dir_tx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   output logic [DATA_W-1:0] rdata,
   output logic [HYST_W-1:0] hyst_sel
);
   import fifo_win_pkg::*;

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("DATA_W must be at least 8");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("counts must fit the data bus");
      end
      if (HYST_LSB < SRC_W || HYST_LSB + HYST_W > DATA_W) begin : g_bad_hyst
         $error("hysteresis field overlaps source bits or exceeds bus");
      end
   endgenerate

   logic [DATA_W-1:0] scratch, rx_word, tx_word, cnt_word, level;
   lvl_src_e          src;
   logic              mode_wr, lvl_rd, win_rd, cnt_rd;

   assign win_rd = rd_stb & win_sel;
   assign cnt_rd = rd_stb & cnt_sel;
   assign lvl_rd = win_rd & swap_en;

   fwin_mode_store #(
      .DATA_W(DATA_W), .HYST_LSB(HYST_LSB), .HYST_W(HYST_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stb & win_sel), .swap_en(swap_en),
      .wdata(wdata), .scratch(scratch), .src(src), .hyst(hyst_sel),
      .mode_wr(mode_wr)
   );

   fwin_count_ext #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ext (
      .rx_count(rx_count), .tx_count(tx_count), .dir_tx(cnt_dir_tx),
      .rx_word(rx_word), .tx_word(tx_word), .dir_word(cnt_word)
   );

   fwin_level_sel #(.DATA_W(DATA_W)) u_level (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .lvl_rd(lvl_rd),
      .src(src), .rx_word(rx_word), .tx_word(tx_word), .level(level)
   );

   always_comb begin
      if (win_rd)      rdata = swap_en ? level : scratch;
      else if (cnt_rd) rdata = cnt_word;
      else             rdata = '0;
   end

   assert_sel_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_sel, cnt_sel}));

   assert_no_rw_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count <= CNT_MAX) && (tx_count <= CNT_MAX));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> (rdata == '0));

   assert_cnt_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && cnt_sel && !cnt_dir_tx) |-> (rdata == DATA_W'(rx_count)));
endmodule

// File: tb/fifo_level_window_test.sv
module fifo_level_window_test;
   typedef struct packed {
      logic [1:0] op;    // 0 idle, 1 write shared, 2 read shared, 3 read count
      logic       swap;
      logic       dir;
      logic [7:0] wd;
      logic [7:0] rx;
      logic [7:0] tx;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd1},  // R1 scratch reset
      '{2'd1, 1'b0, 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00, 4'd2},
      '{2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hA5, 4'd2},  // R2
      '{2'd1, 1'b1, 1'b0, 8'h01, 8'h00, 8'h00, 8'h00, 4'd4},
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h10, 8'h20, 8'h20, 4'd4},  // R4 mode 01
      '{2'd1, 1'b1, 1'b0, 8'h02, 8'h00, 8'h00, 8'h00, 4'd4},
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h11, 8'h22, 8'h11, 4'd4},  // R4 mode 10
      '{2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 4'd4},
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h80, 8'h05, 8'h80, 4'd4},  // R4 mode 00
      '{2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'hA5, 4'd3},  // R3 scratch intact
      '{2'd1, 1'b1, 1'b0, 8'h03, 8'h00, 8'h00, 8'h00, 4'd5},
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h01, 8'h02, 8'h01, 4'd5},  // R5 first rx
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h01, 8'h02, 8'h02, 4'd5},  // R5 then tx
      '{2'd3, 1'b1, 1'b0, 8'h00, 8'h01, 8'h02, 8'h01, 4'd7},  // R7 count read
      '{2'd2, 1'b0, 1'b0, 8'h00, 8'h01, 8'h02, 8'hA5, 4'd7},  // R7 scratch read
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h01, 8'h02, 8'h01, 4'd7},  // R7 still rx
      '{2'd1, 1'b1, 1'b0, 8'h33, 8'h00, 8'h00, 8'h00, 4'd6},
      '{2'd2, 1'b1, 1'b0, 8'h00, 8'h01, 8'h02, 8'h01, 4'd6},  // R6 restart rx
      '{2'd3, 1'b1, 1'b1, 8'h00, 8'h7F, 8'h44, 8'h44, 4'd9},  // R9 tx dir
      '{2'd0, 1'b1, 1'b0, 8'h00, 8'h7F, 8'h44, 8'h00, 4'd10}  // R10 idle
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0, rd_stb = 1'b0, win_sel = 1'b0, cnt_sel = 1'b0;
   logic       swap_en = 1'b0, cnt_dir_tx = 1'b0;
   logic [7:0] wdata = '0, rx_count = '0, tx_count = '0;
   logic [7:0] rdata;
   logic [1:0] hyst_sel;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   fifo_level_window uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .win_sel(win_sel), .cnt_sel(cnt_sel), .swap_en(swap_en),
      .cnt_dir_tx(cnt_dir_tx), .wdata(wdata), .rx_count(rx_count),
      .tx_count(tx_count), .rdata(rdata), .hyst_sel(hyst_sel)
   );

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // Drive one operation after a falling edge; the read value is sampled
   // mid-low phase, and state updates at the following rising edge.
   task automatic step(logic [1:0] op, logic swap, logic dir, logic [7:0] wd,
                       logic [7:0] rx, logic [7:0] tx, output logic [7:0] got);
      @(negedge clk);
      wr_stb = (op == 2'd1); rd_stb = op[1];
      win_sel = (op == 2'd1) || (op == 2'd2); cnt_sel = (op == 2'd3);
      swap_en = swap; cnt_dir_tx = dir; wdata = wd;
      rx_count = rx; tx_count = tx;
      #3 got = rdata;
      @(posedge clk);
      #1 wr_stb = 1'b0; rd_stb = 1'b0; win_sel = 1'b0; cnt_sel = 1'b0;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] got;
      repeat (3) @(posedge clk);
      #1 check("R1 hyst_sel at reset", {6'd0, hyst_sel}, 8'h00);
      rst_n = 1'b1;
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h09, 8'h0A, got);
      check("R1 level source rx at reset", got, 8'h09);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].op, VEC[i].swap, VEC[i].dir, VEC[i].wd,
              VEC[i].rx, VEC[i].tx, got);
         if (VEC[i].op != 2'd1)
            check($sformatf("R%0d vector %0d", VEC[i].req, i), got, VEC[i].exp);
      end

      check("R8 hyst_sel after 0x33", {6'd0, hyst_sel}, 8'h03);
      step(2'd1, 1'b1, 1'b0, 8'hCC, 8'h00, 8'h00, got);
      check("R8 reserved bits ignored hyst", {6'd0, hyst_sel}, 8'h00);
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h05, 8'h06, got);
      check("R8 reserved bits ignored source", got, 8'h05);
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h05, 8'h06, got);
      check("R8 no alternation after 0xCC", got, 8'h05);

      step(2'd3, 1'b0, 1'b1, 8'h00, 8'h00, 8'h80, got);
      check("R11 count max tx", got, 8'h80);
      step(2'd3, 1'b1, 1'b0, 8'h00, 8'h80, 8'h00, got);
      check("R11 count max rx", got, 8'h80);
      step(2'd3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h80, got);
      check("R9 rx dir zero count", got, 8'h00);

      step(2'd1, 1'b1, 1'b0, 8'h13, 8'h00, 8'h00, got);
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h21, 8'h42, got);
      check("R5 rx first", got, 8'h21);
      step(2'd0, 1'b1, 1'b0, 8'h00, 8'h21, 8'h42, got);
      check("R10 idle", got, 8'h00);
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h22, 8'h43, got);
      check("R7 idle keeps tx next", got, 8'h43);
      step(2'd2, 1'b1, 1'b0, 8'h00, 8'h23, 8'h44, got);
      check("R5 back to rx", got, 8'h23);

      @(negedge clk) rst_n = 1'b0;
      #2 check("R1 hyst_sel after reset", {6'd0, hyst_sel}, 8'h00);
      @(negedge clk) rst_n = 1'b1;
      step(2'd2, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, got);
      check("R1 scratch cleared", got, 8'h00);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule